// File: doc/BRIEF.md
# Multi-Queue Status Flag Bus

This block publishes per-queue threshold status for a bank of queues over a narrow shared flag bus. The queue controller hands it two active-low flag vectors, one bit per queue: an almost-full/almost-empty vector and a packet-ready vector. The block groups the queues into status words of eight, one bit per queue, and places one word at a time on an 8-bit bus together with the index of that word, so a receiver can rebuild the status of every queue.

Three settings are captured while the synchronous master reset is held low and stay fixed until the next reset: the presentation mode (direct, where the receiver names a word with an address and a strobe, or polled, where the block steps through the words on successive clock edges and wraps after the last configured word), the source vector (packet-ready or almost-flag status), and whether the device is the bus master. Several devices can share one bus; a drive-enable output tells the pad logic when this device owns it. A single-bit output also mirrors the flag of one queue named by a queue select input.

Top module: `fb_status_bus`

## Requirements
- R1: While and directly after reset the bus is all ones, the word index is 0, the single-queue flag is 1, and the drive enable equals the master input sampled during reset.
- R2: In direct mode, a strobe at a rising edge with address A makes the bus show bits 8A+7..8A of the source vector (bit b of the word is queue 8A+b) and the word index show A, from that edge on.
- R3: In direct mode without a strobe the last chosen word index is kept, and the bus is reloaded each edge from the current source vector for that word.
- R4: In direct mode, until the first strobe after reset, the bus stays all ones whatever the flag vectors do.
- R5: In polled mode the first edge after reset loads word 0, and each later edge loads the next word, wrapping from word ACTIVE_WORDS-1 to word 0; the word index shows the word on the bus.
- R6: In polled mode the strobe and address inputs do not change which word is loaded.
- R7: The mode input is used only while reset is low; changing it afterwards has no effect until the next reset.
- R8: The packet-mode input sampled at reset picks the source vector: 1 selects the packet-ready vector, 0 the almost-flag vector; flags are active low and passed through unchanged.
- R9: At every edge with the strobe high, in either mode, the drive enable takes the value of the device-select input.
- R10: The single-queue flag output takes, one edge later, the source-vector bit named by the queue select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous master reset, active low; configuration inputs captured while low |
| poll_mode_i | input | 1 | Mode select sampled at reset: 1 polled, 0 direct |
| packet_mode_i | input | 1 | Source select sampled at reset: 1 packet-ready, 0 almost flags |
| master_i | input | 1 | Master select sampled at reset: 1 owns the bus after reset |
| almost_n_i | input | NUM_QUEUES | Active-low almost-full/empty flags, one per queue |
| ready_n_i | input | NUM_QUEUES | Active-low packet-ready flags, one per queue |
| word_addr_i | input | IW | Status word address for direct mode |
| strobe_i | input | 1 | Selection strobe |
| dev_sel_i | input | 1 | Device selected for bus ownership, taken on strobe |
| queue_sel_i | input | QW | Queue whose flag is mirrored on queue_flag_o |
| flag_bus_o | output | WORD_BITS | Status word on the bus |
| bus_oe_o | output | 1 | Drive enable for the shared bus |
| word_idx_o | output | IW | Index of the word on the bus |
| queue_flag_o | output | 1 | Registered flag of the selected queue |

## Verification
The cases that interact are a strobe to a new word address landing on the same edge as a change in the flag vectors, and a strobe that also hands over bus ownership while the polled sequencer is stepping. The bench changes the flag vector, the address, the strobe and the device select at one falling edge, then judges after the next rising edge that the bus carries the new word of the new vector and the enable the new select, with no stale mix. In polled mode it strobes mid-sequence and checks that the index keeps its step while only the enable follows the strobe.

// File: rtl/fb_status_pkg.sv
package fb_status_pkg;
   typedef enum logic {
      FB_DIRECT = 1'b0,
      FB_POLLED = 1'b1
   } fb_mode_e;

   typedef struct packed {
      fb_mode_e mode;
      logic     packet;
      logic     master;
   } fb_cfg_t;
endpackage

// File: rtl/fb_cfg_latch.sv
module fb_cfg_latch
   import fb_status_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    poll_i,
   input  logic    packet_i,
   input  logic    master_i,
   output fb_cfg_t cfg_o
);
   fb_cfg_t cfg_q;

   // Configuration follows its inputs only while reset is held low.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q.mode   <= poll_i ? FB_POLLED : FB_DIRECT;
         cfg_q.packet <= packet_i;
         cfg_q.master <= master_i;
      end
   end

   assign cfg_o = cfg_q;
endmodule

// File: rtl/fb_word_select.sv
module fb_word_select #(
   parameter int WB = 8,
   parameter int NW = 16,
   parameter int IW = 4
) (
   input  logic [NW*WB-1:0] flags_i,
   input  logic [IW-1:0]    idx_i,
   output logic [WB-1:0]    word_o
);
   logic [WB-1:0] words [NW];

   for (genvar w = 0; w < NW; w++) begin : g_word
      assign words[w] = flags_i[w*WB +: WB];
   end

   always_comb begin
      word_o = '1;
      for (int w = 0; w < NW; w++) begin
         if (idx_i == IW'(w)) word_o = words[w];
      end
   end
endmodule

// File: rtl/fb_index_seq.sv
module fb_index_seq #(
   parameter int IW         = 4,
   parameter int ACTIVE     = 16,
   parameter bit HAS_POLLED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          poll_req_i,
   input  logic          strobe_i,
   input  logic [IW-1:0] addr_i,
   output logic          poll_o,
   output logic [IW-1:0] load_idx_o,
   output logic          load_en_o
);
   localparam logic [IW-1:0] LAST = IW'(ACTIVE - 1);

   logic [IW-1:0] held_q;
   logic          held_v_q;
   logic [IW-1:0] ptr_q;
   logic          poll_eff;

   if (HAS_POLLED) begin : g_poll
      assign poll_eff = poll_req_i;
      always_ff @(posedge clk) begin
         if (!rst_n)        ptr_q <= '0;
         else if (poll_eff) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end else begin : g_direct_only
      assign poll_eff = 1'b0;
      assign ptr_q    = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q   <= '0;
         held_v_q <= 1'b0;
      end else if (strobe_i && !poll_eff) begin
         held_q   <= addr_i;
         held_v_q <= 1'b1;
      end
   end

   always_comb begin
      if (poll_eff) begin
         load_idx_o = ptr_q;
         load_en_o  = 1'b1;
      end else begin
         load_idx_o = strobe_i ? addr_i : held_q;
         load_en_o  = strobe_i | held_v_q;
      end
   end

   assign poll_o = poll_eff;
endmodule

// File: rtl/fb_bus_owner.sv
module fb_bus_owner (
   input  logic clk,
   input  logic rst_n,
   input  logic master_i,
   input  logic strobe_i,
   input  logic dev_sel_i,
   output logic oe_o
);
   logic oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        oe_q <= master_i;
      else if (strobe_i) oe_q <= dev_sel_i;
   end

   assign oe_o = oe_q;
endmodule

// File: rtl/fb_status_bus.sv
module fb_status_bus
   import fb_status_pkg::*;
#(
   parameter int NUM_QUEUES   = 128,
   parameter int WORD_BITS    = 8,
   parameter int ACTIVE_WORDS = 16,
   parameter bit HAS_POLLED   = 1'b1,
   localparam int NW = NUM_QUEUES / WORD_BITS,
   localparam int IW = (NW > 1) ? $clog2(NW) : 1,
   localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  poll_mode_i,
   input  logic                  packet_mode_i,
   input  logic                  master_i,
   input  logic [NUM_QUEUES-1:0] almost_n_i,
   input  logic [NUM_QUEUES-1:0] ready_n_i,
   input  logic [IW-1:0]         word_addr_i,
   input  logic                  strobe_i,
   input  logic                  dev_sel_i,
   input  logic [QW-1:0]         queue_sel_i,
   output logic [WORD_BITS-1:0]  flag_bus_o,
   output logic                  bus_oe_o,
   output logic [IW-1:0]         word_idx_o,
   output logic                  queue_flag_o
);
   if (NUM_QUEUES % WORD_BITS != 0) begin : g_bad_split
      $error("NUM_QUEUES must be a multiple of WORD_BITS");
   end
   if (ACTIVE_WORDS < 1 || ACTIVE_WORDS > NW) begin : g_bad_active
      $error("ACTIVE_WORDS must lie in 1..NUM_QUEUES/WORD_BITS");
   end

   fb_cfg_t               cfg;
   logic [NUM_QUEUES-1:0] src_n;
   logic                  poll_q;
   logic [IW-1:0]         load_idx;
   logic                  load_en;
   logic [WORD_BITS-1:0]  word_sel;
   logic [WORD_BITS-1:0]  bus_q;
   logic [IW-1:0]         idx_q;
   logic                  shown_q;
   logic                  qflag_q;

   fb_cfg_latch u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .poll_i   (poll_mode_i),
      .packet_i (packet_mode_i),
      .master_i (master_i),
      .cfg_o    (cfg)
   );

   assign src_n = cfg.packet ? ready_n_i : almost_n_i;

   fb_index_seq #(
      .IW         (IW),
      .ACTIVE     (ACTIVE_WORDS),
      .HAS_POLLED (HAS_POLLED)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .poll_req_i (cfg.mode == FB_POLLED),
      .strobe_i   (strobe_i),
      .addr_i     (word_addr_i),
      .poll_o     (poll_q),
      .load_idx_o (load_idx),
      .load_en_o  (load_en)
   );

   fb_word_select #(
      .WB (WORD_BITS),
      .NW (NW),
      .IW (IW)
   ) u_sel (
      .flags_i (src_n),
      .idx_i   (load_idx),
      .word_o  (word_sel)
   );

   fb_bus_owner u_own (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_i  (master_i),
      .strobe_i  (strobe_i),
      .dev_sel_i (dev_sel_i),
      .oe_o      (bus_oe_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_q   <= '1;
         idx_q   <= '0;
         shown_q <= 1'b0;
         qflag_q <= 1'b1;
      end else begin
         qflag_q <= src_n[queue_sel_i];
         if (load_en) begin
            bus_q   <= word_sel;
            idx_q   <= load_idx;
            shown_q <= 1'b1;
         end
      end
   end

   assign flag_bus_o   = bus_q;
   assign word_idx_o   = idx_q;
   assign queue_flag_o = qflag_q;
endmodule

// File: rtl/fb_status_bus_chk.sv
module fb_status_bus_chk #(
   parameter int WB     = 8,
   parameter int IW     = 4,
   parameter int ACTIVE = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          poll_q,
   input logic          shown_q,
   input logic          strobe_i,
   input logic          dev_sel_i,
   input logic [IW-1:0] word_addr_i,
   input logic [WB-1:0] flag_bus_o,
   input logic [IW-1:0] word_idx_o,
   input logic          bus_oe_o
);
   localparam logic [IW-1:0] LAST = IW'(ACTIVE - 1);

   // R1
   reset_bus_ones_chk: assert property (@(posedge clk)
      !rst_n |=> flag_bus_o == {WB{1'b1}});

   // R2
   direct_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!poll_q && strobe_i) |=> word_idx_o == $past(word_addr_i));

   // R4
   idle_bus_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!poll_q && !shown_q) |-> flag_bus_o == {WB{1'b1}});

   // R5
   poll_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_q && shown_q && word_idx_o != LAST) |=> word_idx_o == $past(word_idx_o) + 1'b1);

   // R5
   poll_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_q && shown_q && word_idx_o == LAST) |=> word_idx_o == '0);

   // R7
   mode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(poll_q));

   // R9
   owner_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |=> bus_oe_o == $past(dev_sel_i));
endmodule

bind fb_status_bus fb_status_bus_chk #(
   .WB     (WORD_BITS),
   .IW     (IW),
   .ACTIVE (ACTIVE_WORDS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .poll_q      (poll_q),
   .shown_q     (shown_q),
   .strobe_i    (strobe_i),
   .dev_sel_i   (dev_sel_i),
   .word_addr_i (word_addr_i),
   .flag_bus_o  (flag_bus_o),
   .word_idx_o  (word_idx_o),
   .bus_oe_o    (bus_oe_o)
);

// File: tb/sim_fb_status_bus.sv
`timescale 1ns/1ps
module sim_fb_status_bus;
   localparam int NQ = 128;
   localparam int WB = 8;
   localparam int NW = 16;
   localparam int IW = 4;
   localparam int QW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          poll_mode = 1'b0;
   logic          packet_mode = 1'b0;
   logic          master = 1'b1;
   logic [NQ-1:0] alm = '1;
   logic [NQ-1:0] rdy = '1;
   logic [IW-1:0] addr = '0;
   logic          strobe = 1'b0;
   logic          dev_sel = 1'b0;
   logic [QW-1:0] qsel = '0;
   logic [WB-1:0] bus;
   logic          oe;
   logic [IW-1:0] idx;
   logic          qflag;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   fb_status_bus u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .poll_mode_i   (poll_mode),
      .packet_mode_i (packet_mode),
      .master_i      (master),
      .almost_n_i    (alm),
      .ready_n_i     (rdy),
      .word_addr_i   (addr),
      .strobe_i      (strobe),
      .dev_sel_i     (dev_sel),
      .queue_sel_i   (qsel),
      .flag_bus_o    (bus),
      .bus_oe_o      (oe),
      .word_idx_o    (idx),
      .queue_flag_o  (qflag)
   );

   function automatic logic [WB-1:0] wsel(input logic [NQ-1:0] v, input int w);
      return v[w*WB +: WB];
   endfunction

   function automatic logic [NQ-1:0] pattern(input int seed);
      logic [NQ-1:0] v;
      for (int i = 0; i < NQ; i++) v[i] = ((i * 7 + seed * 13 + (i >> 3)) % 5) != 0;
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic pm, input logic pk, input logic ms);
      @(negedge clk);
      rst_n = 1'b0; poll_mode = pm; packet_mode = pk; master = ms;
      strobe = 1'b0; dev_sel = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0; poll_mode = 1'b0; packet_mode = 1'b0; master = 1'b0;
      alm = pattern(1);
      repeat (3) @(negedge clk);
      chk("R1 bus", 32'(bus), 32'hFF);
      chk("R1 idx", 32'(idx), 0);
      chk("R1 qflag", 32'(qflag), 1);
      chk("R1 oe slave", 32'(oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bus after release", 32'(bus), 32'hFF);
   endtask

   task automatic t_before_select();
      do_reset(1'b0, 1'b0, 1'b1);
      chk("R1 oe master", 32'(oe), 1);
      for (int k = 0; k < 4; k++) begin
         alm = pattern(k + 3);
         @(negedge clk);
         chk("R4 bus idle", 32'(bus), 32'hFF);
      end
   endtask

   task automatic t_direct();
      int ws [4] = '{5, 0, 15, 9};
      do_reset(1'b0, 1'b0, 1'b1);
      alm = pattern(2);
      foreach (ws[i]) begin
         addr = IW'(ws[i]); strobe = 1'b1;
         @(negedge clk);
         strobe = 1'b0;
         chk("R2 word", 32'(bus), 32'(wsel(alm, ws[i])));
         chk("R2 idx", 32'(idx), 32'(ws[i]));
      end
   endtask

   task automatic t_direct_hold();
      addr = 4'd3; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0; addr = 4'd12;
      alm = pattern(8);
      @(negedge clk);
      chk("R3 idx kept", 32'(idx), 3);
      chk("R3 live word", 32'(bus), 32'(wsel(alm, 3)));
   endtask

   task automatic t_polled();
      alm = pattern(4);
      do_reset(1'b1, 1'b0, 1'b1);
      for (int k = 0; k < NW + 3; k++) begin
         if (k == 6) begin strobe = 1'b1; addr = 4'd2; end
         @(negedge clk);
         strobe = 1'b0;
         chk("R5 idx", 32'(idx), 32'(k % NW));
         chk("R5 word", 32'(bus), 32'(wsel(alm, k % NW)));
         if (k == 6) chk("R6 strobe ignored", 32'(idx), 6);
      end
   endtask

   task automatic t_mode_locked();
      do_reset(1'b0, 1'b0, 1'b1);
      poll_mode = 1'b1;
      addr = 4'd7; strobe = 1'b1; alm = pattern(5);
      @(negedge clk);
      strobe = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 still direct", 32'(idx), 7);
      poll_mode = 1'b0;
   endtask

   task automatic t_packet();
      alm = pattern(6); rdy = pattern(9);
      do_reset(1'b0, 1'b1, 1'b1);
      addr = 4'd11; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      chk("R8 ready word", 32'(bus), 32'(wsel(rdy, 11)));
      do_reset(1'b0, 1'b0, 1'b1);
      addr = 4'd11; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      chk("R8 almost word", 32'(bus), 32'(wsel(alm, 11)));
   endtask

   task automatic t_owner();
      do_reset(1'b1, 1'b0, 1'b1);
      strobe = 1'b1; dev_sel = 1'b0;
      @(negedge clk);
      chk("R9 release", 32'(oe), 0);
      strobe = 1'b0; dev_sel = 1'b1;
      @(negedge clk);
      chk("R9 no strobe", 32'(oe), 0);
      strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      chk("R9 take", 32'(oe), 1);
   endtask

   task automatic t_discrete();
      alm = pattern(7); rdy = pattern(10);
      do_reset(1'b0, 1'b1, 1'b1);
      for (int q = 0; q < NQ; q += 37) begin
         qsel = QW'(q);
         @(negedge clk);
         chk("R10 queue flag", 32'(qflag), 32'(rdy[q]));
      end
   endtask

   task automatic t_simultaneous();
      do_reset(1'b0, 1'b0, 1'b0);
      alm = pattern(11); addr = 4'd1; strobe = 1'b1;
      @(negedge clk);
      alm = pattern(12); addr = 4'd14; dev_sel = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      chk("R2 same-edge word", 32'(bus), 32'(wsel(alm, 14)));
      chk("R9 same-edge oe", 32'(oe), 1);
   endtask

   initial begin
      t_reset_state();
      t_before_select();
      t_direct();
      t_direct_hold();
      t_polled();
      t_mode_locked();
      t_packet();
      t_owner();
      t_discrete();
      t_simultaneous();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule